// File: doc/BRIEF.md
# Two-Line Level Interrupt Router

This block collects 32 level-sensitive interrupt sources and presents them to a processor on two interrupt lines. Each source input first passes through a two-flop synchronizer. Each source then has an enable bit and a routing bit. A source whose synchronized level is high and whose enable is set shows up in the status word of the line its routing bit selects.

Software never rewrites the enable word directly. One register address sets enable bits and another clears them, each acting only where the written data holds a one. Because of this, separate agents can change their own sources without a read-modify-write race. Bit 31 of the enable word also acts as a master gate: while it is clear, both processor lines stay low.

The register port is a plain single-cycle bus with valid, write, address, write data and read data. Read data is combinational and valid in the cycle of the read.

Top module: `irq_router_ctl`

## Requirements
- R1: After reset the enable word and the routing word are 0, both `cpu_irq` bits are 0, and reads of offsets 0x00, 0x04, 0x20 and 0x34 return 0.
- R2: A write to offset 0x34 sets every enable bit where the write data is 1 and leaves the other enable bits unchanged. A read of offset 0x34 returns the current enable word.
- R3: A write to offset 0x38 clears every enable bit where the write data is 1 and leaves the other enable bits unchanged. Writing all ones clears every enable bit. A read of offset 0x38 returns 0.
- R4: Offset 0x20 holds the routing word and reads it back. A routing bit of 0 sends its source to line 0 (`cpu_irq[0]`), and a routing bit of 1 sends it to line 1 (`cpu_irq[1]`).
- R5: A read of offset 0x00 returns raw AND enable AND NOT routing. A read of offset 0x04 returns raw AND enable AND routing.
- R6: A read of offset 0x30 returns the source inputs delayed by two clock edges. A change of `src_level` applied between edges is visible after the second rising edge and not after the first.
- R7: `cpu_irq[k]` is the OR of the status word for line k, ANDed with enable bit 31. While enable bit 31 is 0, both lines are 0.
- R8: Sources are not latched. When an input falls, its status bit and the line it drove fall two edges later, and no acknowledge write is needed.
- R9: Writes to offsets 0x00, 0x04, 0x30 or to any unmapped offset change neither the enable word nor the routing word. Reads of unmapped offsets return 0.
- R10: `bus_rdata` is 0 in any cycle that is not a read (`bus_valid` low, or `bus_write` high).

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, 0 when no read |
| src_level | input | 32 | Asynchronous level interrupt inputs |
| cpu_irq | output | 2 | Processor interrupt lines 0 and 1 |

## Verification
On every cycle the assertions check these behaviours:
- the one-sided effect of set and clear writes on the enable word;
- that writes to other addresses leave the enable and routing state untouched;
- the master gate on both lines;
- that each asserted line has at least one live source routed to it;
- the two-edge synchronizer delay;
- that the read bus is quiet outside reads.

Only the bench's scenarios show the following:
- the exact status words and read-back values under mixed random routing and enables;
- the reset values;
- the falling of a line once its source drops without any acknowledge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned SRC_W      = 32;
  localparam int unsigned GATE_BIT   = SRC_W - 1;
  localparam int unsigned NUM_LINES  = 2;

  // Register offsets (byte addresses)
  localparam int unsigned OFS_STAT_L0 = 'h00;
  localparam int unsigned OFS_STAT_L1 = 'h04;
  localparam int unsigned OFS_ROUTE   = 'h20;
  localparam int unsigned OFS_RAW     = 'h30;
  localparam int unsigned OFS_EN_SET  = 'h34;
  localparam int unsigned OFS_EN_CLR  = 'h38;

  typedef logic [SRC_W-1:0] src_vec_t;

  // Status word of one line: live, enabled sources whose routing bit selects it
  function automatic src_vec_t line_status(src_vec_t raw, src_vec_t en,
                                           src_vec_t route, logic line);
    return raw & en & (line ? route : ~route);
  endfunction

  // Line output: any status bit, qualified by the master gate bit
  function automatic logic line_out(src_vec_t status, src_vec_t en);
    return (|status) & en[GATE_BIT];
  endfunction

  function automatic src_vec_t apply_set(src_vec_t en, src_vec_t mask);
    return en | mask;
  endfunction

  function automatic src_vec_t apply_clr(src_vec_t en, src_vec_t mask);
    return en & ~mask;
  endfunction
endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] ff_q;
      always_ff @(posedge clk) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= d_async;
      end
      assign q_sync = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] pipe_q;
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_async};
      end
      assign q_sync = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_router_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_hit,
  input  logic     clr_hit,
  input  logic     route_hit,
  input  src_vec_t wdata,
  output src_vec_t en_q,
  output src_vec_t route_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
    end else begin
      if (set_hit)   en_q    <= apply_set(en_q, wdata);
      else if (clr_hit) en_q <= apply_clr(en_q, wdata);
      if (route_hit) route_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_route_logic.sv
module irq_route_logic
  import irq_router_pkg::*;
(
  input  src_vec_t             raw,
  input  src_vec_t             en,
  input  src_vec_t             route,
  output src_vec_t             stat_l0,
  output src_vec_t             stat_l1,
  output logic [NUM_LINES-1:0] line_irq
);
  assign stat_l0 = line_status(raw, en, route, 1'b0);
  assign stat_l1 = line_status(raw, en, route, 1'b1);
  assign line_irq[0] = line_out(stat_l0, en);
  assign line_irq[1] = line_out(stat_l1, en);
endmodule

// File: rtl/irq_router_ctl.sv
module irq_router_ctl
  import irq_router_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SRC_W-1:0]  bus_wdata,
  output logic [SRC_W-1:0]  bus_rdata,
  input  logic [SRC_W-1:0]  src_level,
  output logic [NUM_LINES-1:0] cpu_irq
);
  localparam logic [ADDR_W-1:0] A_STAT_L0 = ADDR_W'(OFS_STAT_L0);
  localparam logic [ADDR_W-1:0] A_STAT_L1 = ADDR_W'(OFS_STAT_L1);
  localparam logic [ADDR_W-1:0] A_ROUTE   = ADDR_W'(OFS_ROUTE);
  localparam logic [ADDR_W-1:0] A_RAW     = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_EN_SET  = ADDR_W'(OFS_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR  = ADDR_W'(OFS_EN_CLR);

  // Named internal events for the checker
  logic     wr_strobe, rd_strobe;
  logic     set_hit, clr_hit, route_hit;
  src_vec_t raw_q, en_q, type_q;
  src_vec_t stat_l0, stat_l1;

  assign wr_strobe = bus_valid &  bus_write;
  assign rd_strobe = bus_valid & ~bus_write;
  assign set_hit   = wr_strobe & (bus_addr == A_EN_SET);
  assign clr_hit   = wr_strobe & (bus_addr == A_EN_CLR);
  assign route_hit = wr_strobe & (bus_addr == A_ROUTE);

  irq_level_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (src_level),
    .q_sync  (raw_q)
  );

  irq_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_hit   (set_hit),
    .clr_hit   (clr_hit),
    .route_hit (route_hit),
    .wdata     (bus_wdata),
    .en_q      (en_q),
    .route_q   (type_q)
  );

  irq_route_logic u_route (
    .raw      (raw_q),
    .en       (en_q),
    .route    (type_q),
    .stat_l0  (stat_l0),
    .stat_l1  (stat_l1),
    .line_irq (cpu_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_strobe) begin
      case (bus_addr)
        A_STAT_L0: bus_rdata = stat_l0;
        A_STAT_L1: bus_rdata = stat_l1;
        A_ROUTE:   bus_rdata = type_q;
        A_RAW:     bus_rdata = raw_q;
        A_EN_SET:  bus_rdata = en_q;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [SRC_W-1:0]     bus_wdata,
  input logic [SRC_W-1:0]     bus_rdata,
  input logic [SRC_W-1:0]     src_level,
  input logic [NUM_LINES-1:0] cpu_irq,
  input src_vec_t             en_q,
  input src_vec_t             type_q,
  input src_vec_t             raw_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic is_set, is_clr, is_other_wr;
  assign is_set = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_EN_SET);
  assign is_clr = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_EN_CLR);
  assign is_other_wr = bus_valid && bus_write && !is_set && !is_clr &&
                       bus_addr != ADDR_W'(OFS_ROUTE);

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_set |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)) &&
               ((en_q & ~$past(bus_wdata)) == ($past(en_q) & ~$past(bus_wdata))));

  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> ((en_q & $past(bus_wdata)) == '0) &&
               ((en_q & ~$past(bus_wdata)) == ($past(en_q) & ~$past(bus_wdata))));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_other_wr |=> $stable(en_q) && $stable(type_q));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[GATE_BIT] |-> cpu_irq == '0);

  assert_line0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq[0] |-> |(raw_q & en_q & ~type_q));

  assert_line1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq[1] |-> |(raw_q & en_q & type_q));

  assert_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> raw_q == $past(src_level, 2));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |-> bus_rdata == '0);
endmodule

bind irq_router_ctl irq_router_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_irq_router_ctl.sv
module test_irq_router_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [31:0]   src_level = '0;
  logic [1:0]    cpu_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_en = '0, m_ty = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router_ctl #(.ADDR_W(AW)) i_irq_router_ctl (.*);

  function automatic logic [31:0] exp_stat(logic [31:0] raw, logic [31:0] en,
                                           logic [31:0] ty, int line);
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = raw[i] && en[i] && (ty[i] == (line == 1));
    return r;
  endfunction

  function automatic logic [1:0] exp_irq(logic [31:0] raw, logic [31:0] en,
                                         logic [31:0] ty);
    logic [1:0] r;
    r[0] = (exp_stat(raw, en, ty, 0) != 0) && en[31];
    r[1] = (exp_stat(raw, en, ty, 1) != 0) && en[31];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    rd(8'h34, v); check({tag, " R2 enable readback"}, v, m_en);
    rd(8'h20, v); check({tag, " R4 route readback"}, v, m_ty);
    rd(8'h30, v); check({tag, " R6 raw"}, v, src_level);
    rd(8'h00, v); check({tag, " R5 status line0"}, v, exp_stat(src_level, m_en, m_ty, 0));
    rd(8'h04, v); check({tag, " R5 status line1"}, v, exp_stat(src_level, m_en, m_ty, 1));
    check({tag, " R7 cpu_irq"}, {30'd0, cpu_irq}, {30'd0, exp_irq(src_level, m_en, m_ty)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h34, v); check("R1 enable after reset", v, 0);
    rd(8'h20, v); check("R1 route after reset", v, 0);
    rd(8'h00, v); check("R1 status0 after reset", v, 0);
    rd(8'h04, v); check("R1 status1 after reset", v, 0);
    check("R1 cpu_irq after reset", {30'd0, cpu_irq}, 0);

    // R10 idle read bus
    @(negedge clk); #1 check("R10 rdata idle", bus_rdata, 0);

    // R6 two-edge delay
    @(negedge clk); src_level = 32'hA5A5_0F0F;
    rd(8'h30, v); check("R6 raw after one edge", v, 32'h0);
    rd(8'h30, v); check("R6 raw after two edges", v, 32'hA5A5_0F0F);

    // R7 gate off: sources enabled but bit 31 clear
    wr(8'h34, 32'h0000_0F0F); m_en = 32'h0000_0F0F; settle();
    check("R7 gate off line0", {31'd0, cpu_irq[0]}, 0);
    check_all("gate-off");
    wr(8'h34, 32'h8000_0000); m_en |= 32'h8000_0000; settle();
    check("R7 gate on line0", {31'd0, cpu_irq[0]}, 1);

    // R4 route everything to line1
    wr(8'h20, 32'hFFFF_FFFF); m_ty = '1; settle();
    check("R4 line1 only", {30'd0, cpu_irq}, 2'b10);
    check_all("route1");

    // R9 writes to read-only / unmapped offsets ignored
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'h0); wr(8'h30, 32'h1234_5678);
    wr(8'h10, 32'hFFFF_FFFF); settle();
    check_all("R9 ignored writes");
    rd(8'h10, v); check("R9 unmapped read", v, 0);
    rd(8'h38, v); check("R3 clear offset reads zero", v, 0);

    // R8 level, not latched
    wr(8'h20, 32'h0); m_ty = '0;
    @(negedge clk); src_level = 32'h0;
    rd(8'h00, v); check("R8 status one edge after drop", v, exp_stat(32'hA5A5_0F0F, m_en, m_ty, 0));
    rd(8'h00, v); check("R8 status two edges after drop", v, 0);
    check("R8 line dropped", {30'd0, cpu_irq}, 0);

    // R3 clear all
    wr(8'h38, 32'hFFFF_FFFF); m_en = '0; src_level = '1; settle();
    check_all("R3 clear all");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 3);
      logic [31:0] d = $urandom();
      case (op)
        0: begin wr(8'h34, d); m_en |= d; end
        1: begin wr(8'h38, d); m_en &= ~d; end
        2: begin wr(8'h20, d); m_ty = d; end
        default: begin @(negedge clk); src_level = d; end
      endcase
      if ((n % 4) == 3) begin settle(); check_all("random R2 R3 R4 R5 R7"); end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule